// File: doc/BRIEF.md
# Flash Sector-Erase Command Decoder

This block sits on the write side of a parallel NOR flash command interface. Each write is one strobe that carries an address and a data byte. The block watches those writes for the six-write sector-erase sequence. When the sequence is complete, it opens a timed acceptance window. While the window is open, more sector-erase writes can be added to a sector bitmap. When the window runs out, the block starts the erase engine with a one-cycle pulse and keeps the bitmap steady until the engine reports completion.

Time is counted in whole microseconds from a one-cycle tick input. The window length is a parameter, 50 ticks by default. Every accepted sector write restarts the count. Any write in the window that is neither a sector-erase command nor an erase-suspend command drops the buffered sectors and puts the block back in array-read mode. A wrong value in any unlock write has the same effect.

Top module: `sector_erase_decoder`

## Requirements
- R1: Synchronous active-low reset clears the sector bitmap to zero, drives `read_array` to 1 and drives `win_expired` and `erase_go` to 0.
- R2: Six writes in this order open the window: 0xAA at address 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, then 0x30 at any address whose bits [14:11] give a sector index 0..10. After the sixth write, `read_array`=0, `win_expired`=0 and bit k of `sect_mask` is set, where k is that index.
- R3: A write whose address or data does not match the expected unlock or set-up value returns the block to read mode with an empty bitmap. The rest of the sequence written after it does not open the window.
- R4: In the window, each write of 0x30 with a valid sector index ORs that sector's bit into `sect_mask`. Sectors may be added in any order, and the bitmap can hold all 11 sectors.
- R5: The window expires on the 50th `us_tick` after the last accepted sector write. On that cycle `erase_go` is 1 and `win_expired` becomes 1. After 49 ticks the window is still open.
- R6: Each accepted sector write in the window restarts the tick count from zero.
- R7: In the window, a write with data other than 0x30 (valid sector) or 0xB0 clears `sect_mask` and sets `read_array` to 1.
- R8: In the window, a write of 0xB0 (erase suspend) leaves the bitmap unchanged, keeps the window open and does not restart the tick count.
- R9: While `win_expired` is 1, writes have no effect on `sect_mask` or the outputs. When `erase_done` is 1, the block returns to read mode with `sect_mask`=0 and `win_expired`=0.
- R10: A 0x30 write whose sector index is 11 or above is treated as an invalid command. As the sixth write it aborts the sequence; in the window it aborts the window (bitmap cleared, read mode).
- R11: `erase_go` is high for exactly one cycle per erase and only when the window expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle write strobe marking a completed bus write |
| wr_addr | input | 15 | Word address of the write; bits [14:11] give the sector |
| wr_data | input | 8 | Command data of the write |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| erase_done | input | 1 | Erase engine finished; return to read mode |
| sect_mask | output | 11 | Bitmap of sectors selected for erase |
| erase_go | output | 1 | One-cycle pulse that starts the erase engine |
| win_expired | output | 1 | 0 while the window is open, 1 once erasure has started |
| read_array | output | 1 | 1 when the block is in array-read mode |

## Verification
Some properties hold on every cycle, and the assertions check these:
- `erase_go` is a single pulse that coincides with the rise of `win_expired`.
- Read mode always has an empty bitmap.
- An open window always has at least one sector, and its bitmap only gains bits.
- The bitmap stays frozen while the erase runs.

Other behaviour can only be shown by directed scenarios:
- the exact command values and order;
- the exact 50-tick expiry point;
- re-arming by a late sector write;
- suspend not restarting the count;
- aborts on bad unlock writes and on out-of-range sectors.

// File: rtl/sed_pkg.sv
// Shared types for the sector-erase command decoder.
package sed_pkg;

    // Decoder states. Every state before ST_WINDOW still reads array data.
    typedef enum logic [2:0] {
        ST_READ,
        ST_UL1,
        ST_UL2,
        ST_SETUP,
        ST_UL3,
        ST_UL4,
        ST_WINDOW,
        ST_ERASE
    } sed_state_e;

    // Classification of a single bus write.
    typedef struct packed {
        logic unlock_a;   // first unlock value at its address
        logic unlock_b;   // second unlock value at its address
        logic setup;      // erase set-up command at its address
        logic sect_cmd;   // sector erase command with an in-range sector
        logic suspend;    // erase suspend command
    } sed_cls_t;

endpackage

// File: rtl/sed_cycle_class.sv
// Combinational classifier for one bus write.
// Compares address and data against the command constants and decodes the
// sector index in the upper address bits into a one-hot vector.
// Assumes the sector field occupies addr[ADDR_W-1:SECT_LSB].
module sed_cycle_class
    import sed_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int NUM_SECT = 11,
    parameter int SECT_LSB = 11,
    parameter logic [ADDR_W-1:0] ADDR_A  = 'h555,
    parameter logic [ADDR_W-1:0] ADDR_B  = 'h2AA,
    parameter logic [DATA_W-1:0] DATA_A  = 'hAA,
    parameter logic [DATA_W-1:0] DATA_B  = 'h55,
    parameter logic [DATA_W-1:0] DATA_SU = 'h80,
    parameter logic [DATA_W-1:0] DATA_SE = 'h30,
    parameter logic [DATA_W-1:0] DATA_SP = 'hB0
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   data,
    output sed_cls_t            cls,
    output logic [NUM_SECT-1:0] sect_onehot
);
    localparam int SECT_W = ADDR_W - SECT_LSB;

    logic [SECT_W-1:0] sect_idx;
    assign sect_idx = addr[ADDR_W-1:SECT_LSB];

    // One-hot sector decode; indices past NUM_SECT map to no bit.
    for (genvar g = 0; g < NUM_SECT; g++) begin : g_dec
        assign sect_onehot[g] = (sect_idx == SECT_W'(g));
    end

    // Match each command pattern.
    always_comb begin
        cls.unlock_a = (addr == ADDR_A) && (data == DATA_A);
        cls.unlock_b = (addr == ADDR_B) && (data == DATA_B);
        cls.setup    = (addr == ADDR_A) && (data == DATA_SU);
        cls.sect_cmd = (data == DATA_SE) && (|sect_onehot);
        cls.suspend  = (data == DATA_SP);
    end
endmodule

// File: rtl/sed_win_timer.sv
// Acceptance-window timer counting microsecond ticks.
// Holds at zero while not running or when restarted. Flags expiry on the
// tick that completes WIN_US ticks since the last restart.
// Assumes the caller gives restart priority over expiry.
module sed_win_timer #(
    parameter int WIN_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    localparam int CNT_W = $clog2(WIN_US + 1);

    logic [CNT_W-1:0] cnt;

    // Tick counter, cleared by reset, restart or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && tick && (cnt == CNT_W'(WIN_US - 1));
endmodule

// File: rtl/sed_sector_buf.sv
// Sector bitmap register for the erase buffer.
// Clear has priority over add. Added sectors are ORed in.
module sed_sector_buf #(
    parameter int NUM_SECT = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                add,
    input  logic [NUM_SECT-1:0] add_mask,
    output logic [NUM_SECT-1:0] mask
);
    // Accumulate the selected sectors.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mask <= '0;
        end else if (add) begin
            mask <= mask | add_mask;
        end
    end
endmodule

// File: rtl/sector_erase_decoder.sv
// Sector-erase command decoder.
// Tracks the six-write erase sequence and then holds an acceptance window in
// which more sectors can be queued. When the window expires it pulses
// erase_go and holds the bitmap until erase_done.
// Assumes wr_stb and us_tick are single-cycle pulses synchronous to clk.
module sector_erase_decoder
    import sed_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int NUM_SECT = 11,
    parameter int SECT_LSB = 11,
    parameter int WIN_US   = 50
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                us_tick,
    input  logic                erase_done,
    output logic [NUM_SECT-1:0] sect_mask,
    output logic                erase_go,
    output logic                win_expired,
    output logic                read_array
);
    sed_state_e          st, nxt;
    sed_cls_t            cls;
    logic [NUM_SECT-1:0] onehot;
    logic                buf_clr, buf_add, tmr_restart, expire;

    sed_cycle_class #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .NUM_SECT(NUM_SECT), .SECT_LSB(SECT_LSB)
    ) u_class (
        .addr(wr_addr), .data(wr_data), .cls(cls), .sect_onehot(onehot)
    );

    sed_win_timer #(.WIN_US(WIN_US)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(st == ST_WINDOW),
        .restart(tmr_restart), .tick(us_tick), .expire(expire)
    );

    sed_sector_buf #(.NUM_SECT(NUM_SECT)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .add(buf_add),
        .add_mask(onehot), .mask(sect_mask)
    );

    // Next-state and buffer/timer control.
    always_comb begin
        nxt         = st;
        buf_clr     = 1'b0;
        buf_add     = 1'b0;
        tmr_restart = 1'b0;
        case (st)
            ST_READ:  if (wr_stb && cls.unlock_a) nxt = ST_UL1;
            ST_UL1:   if (wr_stb) nxt = cls.unlock_b ? ST_UL2   : ST_READ;
            ST_UL2:   if (wr_stb) nxt = cls.setup    ? ST_SETUP : ST_READ;
            ST_SETUP: if (wr_stb) nxt = cls.unlock_a ? ST_UL3   : ST_READ;
            ST_UL3:   if (wr_stb) nxt = cls.unlock_b ? ST_UL4   : ST_READ;
            ST_UL4: begin
                if (wr_stb) begin
                    if (cls.sect_cmd) begin
                        nxt         = ST_WINDOW;
                        buf_add     = 1'b1;
                        tmr_restart = 1'b1;
                    end else begin
                        nxt = ST_READ;
                    end
                end
            end
            ST_WINDOW: begin
                if (wr_stb && cls.sect_cmd) begin
                    buf_add     = 1'b1;
                    tmr_restart = 1'b1;
                end else if (wr_stb && !cls.suspend) begin
                    nxt     = ST_READ;
                    buf_clr = 1'b1;
                end else if (expire) begin
                    nxt = ST_ERASE;
                end
            end
            ST_ERASE: begin
                if (erase_done) begin
                    nxt     = ST_READ;
                    buf_clr = 1'b1;
                end
            end
            default: begin
                nxt     = ST_READ;
                buf_clr = 1'b1;
            end
        endcase
    end

    // State register and erase start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_READ;
            erase_go <= 1'b0;
        end else begin
            st       <= nxt;
            erase_go <= (st == ST_WINDOW) && (nxt == ST_ERASE);
        end
    end

    assign win_expired = (st == ST_ERASE);
    assign read_array  = (st != ST_WINDOW) && (st != ST_ERASE);
endmodule

// File: rtl/sed_checker.sv
// Port-level property checker for the sector-erase command decoder.
module sed_checker #(
    parameter int NUM_SECT = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic                erase_go,
    input logic                win_expired,
    input logic                read_array,
    input logic                erase_done,
    input logic [NUM_SECT-1:0] sect_mask
);
    logic in_win;
    assign in_win = !read_array && !win_expired;

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (read_array && !win_expired && !erase_go && sect_mask == '0));

    p_go_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> !erase_go);

    p_go_on_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> win_expired);

    p_rose_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_expired) |-> erase_go);

    p_expired_not_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_expired |-> !read_array);

    p_read_mask_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        read_array |-> (sect_mask == '0));

    p_window_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |-> (sect_mask != '0));

    p_mask_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win ##1 in_win) |-> ((sect_mask & $past(sect_mask)) == $past(sect_mask)));

    p_erase_mask_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_expired && !erase_done) |=> $stable(sect_mask));
endmodule

bind sector_erase_decoder sed_checker #(.NUM_SECT(NUM_SECT)) u_sed_chk (
    .clk(clk), .rst_n(rst_n), .erase_go(erase_go), .win_expired(win_expired),
    .read_array(read_array), .erase_done(erase_done), .sect_mask(sect_mask)
);

// File: tb/sector_erase_decoder_test.sv
`timescale 1ns/1ps
// Directed bench for the sector-erase command decoder.
module sector_erase_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        us_tick = 1'b0;
    logic        erase_done = 1'b0;
    logic [10:0] sect_mask;
    logic        erase_go, win_expired, read_array;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sector_erase_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .us_tick(us_tick), .erase_done(erase_done),
        .sect_mask(sect_mask), .erase_go(erase_go),
        .win_expired(win_expired), .read_array(read_array)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp_v);
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); us_tick = 1'b1;
            @(negedge clk); us_tick = 1'b0;
        end
    endtask

    task automatic done_pulse();
        @(negedge clk); erase_done = 1'b1;
        @(negedge clk); erase_done = 1'b0;
    endtask

    function automatic logic [14:0] sa(input int s);
        return {4'(s), 11'h000};
    endfunction

    task automatic full_seq(input int s);
        wr(15'h555, 8'hAA); wr(15'h2AA, 8'h55); wr(15'h555, 8'h80);
        wr(15'h555, 8'hAA); wr(15'h2AA, 8'h55); wr(sa(s), 8'h30);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 mask", sect_mask, 0);
        chk("R1 read_array", read_array, 1);
        chk("R1 win_expired", win_expired, 0);
        chk("R1 erase_go", erase_go, 0);
        full_seq(4);
        chk("R2 window open before reset", read_array, 0);
        do_reset();
        chk("R1 mask after mid-window reset", sect_mask, 0);
        chk("R1 read after mid-window reset", read_array, 1);
    endtask

    task automatic t_basic();
        full_seq(3);
        chk("R2 mask", sect_mask, 11'h008);
        chk("R2 read_array", read_array, 0);
        chk("R2 win_expired", win_expired, 0);
        ticks(49);
        chk("R5 open after 49 ticks", win_expired, 0);
        chk("R11 no go before expiry", erase_go, 0);
        ticks(1);
        chk("R5 go at 50th tick", erase_go, 1);
        chk("R5 expired at 50th tick", win_expired, 1);
        @(negedge clk);
        chk("R11 go single cycle", erase_go, 0);
        done_pulse();
        chk("R9 read after done", read_array, 1);
        chk("R9 mask cleared after done", sect_mask, 0);
        chk("R9 expired cleared after done", win_expired, 0);
    endtask

    task automatic t_multi();
        full_seq(10);
        ticks(30);
        wr(sa(0), 8'h30);
        wr(sa(7), 8'h30);
        chk("R4 mask out of order", sect_mask, 11'h481);
        ticks(49);
        chk("R6 window re-armed", win_expired, 0);
        wr(15'h123, 8'hB0);
        chk("R8 suspend keeps mask", sect_mask, 11'h481);
        chk("R8 suspend keeps window", read_array, 0);
        ticks(1);
        chk("R8 suspend did not restart count", win_expired, 1);
        wr(15'h555, 8'hAA);
        wr(sa(2), 8'h30);
        wr(15'h000, 8'hF0);
        chk("R9 writes ignored mask", sect_mask, 11'h481);
        chk("R9 writes ignored expired", win_expired, 1);
        chk("R9 writes ignored read", read_array, 0);
        done_pulse();
        chk("R9 read after done", read_array, 1);
    endtask

    task automatic t_all_abort();
        full_seq(0);
        for (int s = 1; s < 11; s++) wr(sa(s), 8'h30);
        chk("R4 all sectors", sect_mask, 11'h7FF);
        wr(15'h123, 8'hF0);
        chk("R7 abort mask", sect_mask, 0);
        chk("R7 abort read", read_array, 1);
        ticks(50);
        chk("R7 no erase after abort", win_expired, 0);
    endtask

    task automatic t_bad_unlock();
        wr(15'h555, 8'hAA); wr(15'h2AA, 8'h54);
        chk("R3 bad data read", read_array, 1);
        wr(15'h555, 8'h80); wr(15'h555, 8'hAA); wr(15'h2AA, 8'h55); wr(sa(1), 8'h30);
        chk("R3 bad data no window", read_array, 1);
        chk("R3 bad data mask", sect_mask, 0);
        wr(15'h555, 8'hAA); wr(15'h2AA, 8'h55); wr(15'h555, 8'h80);
        wr(15'h555, 8'hAA); wr(15'h2AB, 8'h55); wr(sa(1), 8'h30);
        chk("R3 bad address no window", read_array, 1);
        chk("R3 bad address mask", sect_mask, 0);
    endtask

    task automatic t_bad_sector();
        full_seq(11);
        chk("R10 sector 11 as sixth write", read_array, 1);
        chk("R10 sector 11 mask", sect_mask, 0);
        full_seq(2);
        chk("R2 window for sector 2", sect_mask, 11'h004);
        wr(sa(15), 8'h30);
        chk("R10 sector 15 in window aborts", read_array, 1);
        chk("R10 sector 15 mask", sect_mask, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_multi();
        t_all_abort();
        t_bad_unlock();
        t_bad_sector();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule